// File: doc/BRIEF.md
# Compare Timer Frame

This block is a physical timer that lives behind a small register bus. A free-running 64-bit system count is an input. The block holds a 64-bit compare value. Software never sees that value directly. It works through a signed 32-bit "time remaining" register instead. Writing that register with a value N arms the compare at the current count plus N. Reading it returns the compare value minus the current count. As the system count advances, the remaining time falls like a down-counter, and it keeps falling after it goes negative.

A control register enables the timer, masks its interrupt, and reports a read-only status. A three-state machine follows the timer condition:

- `TS_OFF`: the timer is disabled.
- `TS_ARMED`: the timer is enabled and the condition is not met.
- `TS_FIRED`: the timer is enabled and the condition is met.

The transitions are:

- `TS_OFF` to `TS_ARMED` on enable when the condition is not met.
- `TS_OFF` to `TS_FIRED` on enable when the condition is met.
- `TS_ARMED` to `TS_FIRED` when the count reaches the compare value.
- `TS_FIRED` to `TS_ARMED` when a new remaining-time write pushes the compare value beyond the count.
- `TS_ARMED` to `TS_OFF` and `TS_FIRED` to `TS_OFF` on disable.

The interrupt is a registered level output.

The same registers can be reached through two views, chosen by a frame-select input: a privileged frame and a user frame. Two permission inputs gate access. When access is denied, reads return zero and writes are ignored.

Top module: `cmp_timer_frame`

## Requirements
- R1: A read at offset 0x028 returns the low 32 bits of (compare value minus the system count present on the request's clock edge), whether the timer is enabled or not.
- R2: A write at offset 0x028 sets the compare value to the system count on that edge plus the write data, sign-extended from 32 to 64 bits.
- R3: After reset the compare value is zero and the control register reads zero. The control register is at offset 0x02C, with bit 0 = enable, bit 1 = interrupt mask and bit 2 = status. Bit 2 ignores writes, and bits 31:3 read as zero.
- R4: While the timer is enabled, the state machine enters `TS_FIRED` on the first clock edge at which (count minus compare), taken as a signed 64-bit value, is at least zero. The status bit then reads 1. The state machine leaves `TS_FIRED` for `TS_ARMED` on the first edge at which that difference is negative.
- R5: While enable is 0, the status bit reads 0, and irq is low from the clock edge after enable is first seen at 0.
- R6: irq is a registered level that is high exactly when the state machine is in `TS_FIRED` and the mask, as sampled on that same edge, is 0.
- R7: In the privileged frame (req_user = 0), an access to either register succeeds only when perm_frame_rw is 1. Otherwise the read data is zero and the write has no effect.
- R8: In the user frame (req_user = 1), an access succeeds only when both perm_frame_rw and perm_user_timer are 1. Otherwise the read data is zero and the write has no effect.
- R9: rsp_valid is high on the cycle after each request and low otherwise, and rsp_rdata carries the read result there. A read of any offset other than 0x028 or 0x02C returns zero, and a write to one has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_count | input | 64 | Free-running system count |
| req_valid | input | 1 | Single-cycle request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | Frame select: 0 = privileged, 1 = user |
| req_addr | input | 12 | Byte offset within the frame |
| req_wdata | input | 32 | Write data |
| perm_frame_rw | input | 1 | Permission for timer access in the privileged frame |
| perm_user_timer | input | 1 | Additional permission for the user frame |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| irq | output | 1 | Level interrupt |

## Verification
A wrong compare value shows up on the very next remaining-time read as a read value that is off by a fixed offset. It also shows up as irq rising on the wrong count, which is visible within the few cycles the bench waits around the expected edge. A state machine stuck in the wrong state appears on the next control read as a wrong status bit, and on irq one edge after the mask or enable changes. A faulty permission gate returns nonzero data on a denied read. A leaked write is caught at the next permitted remaining-time read, because that read is compared against a compare value the bench tracks independently.

// File: rtl/ctf_pkg.sv
package ctf_pkg;
    typedef enum logic [1:0] {
        TS_OFF   = 2'd0,
        TS_ARMED = 2'd1,
        TS_FIRED = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/ctf_access_gate.sv
module ctf_access_gate (
    input  logic frame_user,
    input  logic perm_frame,
    input  logic perm_user,
    output logic ok
);
    // user view needs the privileged permission as well as its own
    assign ok = frame_user ? (perm_frame & perm_user) : perm_frame;
endmodule

// File: rtl/ctf_cond.sv
module ctf_cond #(
    parameter int CNT_W  = 64,
    parameter int VIEW_W = 32
) (
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  compare,
    output logic              met,
    output logic [VIEW_W-1:0] remaining
);
    assign met       = $signed(count - compare) >= $signed({CNT_W{1'b0}});
    assign remaining = VIEW_W'(compare - count);
endmodule

// File: rtl/ctf_state_fsm.sv
module ctf_state_fsm
    import ctf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       mask,
    input  logic       met,
    output tmr_state_e state,
    output logic       irq
);
    tmr_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TS_OFF;
            irq   <= 1'b0;
        end else begin
            state <= nxt;
            irq   <= (nxt == TS_FIRED) && !mask;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TS_OFF:   if (enable) nxt = met ? TS_FIRED : TS_ARMED;
            TS_ARMED: if (!enable) nxt = TS_OFF;
                      else if (met) nxt = TS_FIRED;
            TS_FIRED: if (!enable) nxt = TS_OFF;
                      else if (!met) nxt = TS_ARMED;
            default:  nxt = TS_OFF;
        endcase
    end
endmodule

// File: rtl/cmp_timer_frame.sv
module cmp_timer_frame
    import ctf_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int          CNT_W    = 64,
    parameter int          VIEW_W   = 32,
    parameter logic [11:0] TVAL_OFS = 12'h028,
    parameter logic [11:0] CTRL_OFS = 12'h02C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  sys_count,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [VIEW_W-1:0] req_wdata,
    input  logic              perm_frame_rw,
    input  logic              perm_user_timer,
    output logic              rsp_valid,
    output logic [VIEW_W-1:0] rsp_rdata,
    output logic              irq
);
    localparam int CTRL_PAD = VIEW_W - 3;

    logic              acc_ok;
    logic              met;
    logic [VIEW_W-1:0] remaining;
    logic [CNT_W-1:0]  compare_q;
    logic              ctl_en;
    logic              ctl_mask;
    logic              fired;
    tmr_state_e        st;
    logic              hit_tval;
    logic              hit_ctrl;
    logic [VIEW_W-1:0] rd_mux;

    ctf_access_gate u_gate (
        .frame_user(req_user),
        .perm_frame(perm_frame_rw),
        .perm_user (perm_user_timer),
        .ok        (acc_ok)
    );

    ctf_cond #(.CNT_W(CNT_W), .VIEW_W(VIEW_W)) u_cond (
        .count    (sys_count),
        .compare  (compare_q),
        .met      (met),
        .remaining(remaining)
    );

    ctf_state_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(ctl_en),
        .mask  (ctl_mask),
        .met   (met),
        .state (st),
        .irq   (irq)
    );

    assign fired    = (st == TS_FIRED);
    assign hit_tval = req_valid && acc_ok && (req_addr == ADDR_W'(TVAL_OFS));
    assign hit_ctrl = req_valid && acc_ok && (req_addr == ADDR_W'(CTRL_OFS));

    always_comb begin
        rd_mux = '0;
        if (hit_tval) rd_mux = remaining;
        else if (hit_ctrl) rd_mux = {{CTRL_PAD{1'b0}}, fired & ctl_en, ctl_mask, ctl_en};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            compare_q <= '0;
            ctl_en    <= 1'b0;
            ctl_mask  <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= req_write ? '0 : rd_mux;
            if (hit_tval && req_write)
                compare_q <= sys_count + CNT_W'($signed(req_wdata));
            if (hit_ctrl && req_write) begin
                ctl_en   <= req_wdata[0];
                ctl_mask <= req_wdata[1];
            end
        end
    end
endmodule

// File: rtl/ctf_checker.sv
module ctf_checker #(
    parameter int CNT_W  = 64,
    parameter int VIEW_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              acc_ok,
    input logic              rsp_valid,
    input logic [VIEW_W-1:0] rsp_rdata,
    input logic              irq,
    input logic              ctl_en,
    input logic              ctl_mask,
    input logic              fired,
    input logic [CNT_W-1:0]  compare_q
);
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R9
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R9
    AST_IRQ_NEEDS_FIRED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> fired); // R6
    AST_MASK_SILENCES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !$past(ctl_mask)); // R6
    AST_IRQ_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> !irq); // R5
    AST_DENIED_WRITE_KEEPS_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !acc_ok) |=> $stable(compare_q)); // R7
    AST_DENIED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !acc_ok) |=> (rsp_rdata == '0)); // R8
endmodule

bind cmp_timer_frame ctf_checker #(.CNT_W(CNT_W), .VIEW_W(VIEW_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .acc_ok   (acc_ok),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .irq      (irq),
    .ctl_en   (ctl_en),
    .ctl_mask (ctl_mask),
    .fired    (fired),
    .compare_q(compare_q)
);

// File: tb/cmp_timer_frame_tb.sv
module cmp_timer_frame_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] TVAL = 12'h028;
    localparam logic [11:0] CTRL = 12'h02C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] sys_count = 64'd100;
    logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        perm_frame_rw = 1'b1, perm_user_timer = 1'b0;
    logic        rsp_valid, irq;
    logic [31:0] rsp_rdata;

    int n_chk = 0, n_bad = 0;
    logic [63:0] exp_cmp = '0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_timer_frame dut_i (
        .clk(clk), .rst_n(rst_n), .sys_count(sys_count),
        .req_valid(req_valid), .req_write(req_write), .req_user(req_user),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .perm_frame_rw(perm_frame_rw), .perm_user_timer(perm_user_timer),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock: sample on the edge, then advance the count just after it
    task automatic cyc();
        @(posedge clk);
        #1;
        sys_count = sys_count + 64'd1;
    endtask

    task automatic access(input bit usr, input logic [11:0] a, input bit wr,
                          input logic [31:0] wd, output logic [31:0] rd, output logic [63:0] c);
        req_valid = 1'b1; req_user = usr; req_addr = a; req_write = wr; req_wdata = wd;
        c = sys_count;
        cyc();
        rd = rsp_rdata;
        check(rsp_valid == 1'b1, "R9 rsp_valid", {63'd0, rsp_valid}, 64'd1);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic read_tval(input bit usr, input string req);
        logic [31:0] rd; logic [63:0] c;
        access(usr, TVAL, 1'b0, '0, rd, c);
        check(rd == 32'(exp_cmp - c), req, {32'd0, rd}, {32'd0, 32'(exp_cmp - c)});
    endtask

    task automatic write_tval(input bit usr, input logic [31:0] v);
        logic [31:0] rd; logic [63:0] c;
        access(usr, TVAL, 1'b1, v, rd, c);
        exp_cmp = c + {{32{v[31]}}, v};
    endtask

    task automatic read_ctrl(input logic [31:0] exp, input string req);
        logic [31:0] rd; logic [63:0] c;
        access(1'b0, CTRL, 1'b0, '0, rd, c);
        check(rd == exp, req, {32'd0, rd}, {32'd0, exp});
    endtask

    task automatic write_ctrl(input logic [31:0] v);
        logic [31:0] rd; logic [63:0] c;
        access(1'b0, CTRL, 1'b1, v, rd, c);
    endtask

    task automatic t_reset();
        check(rsp_valid == 1'b0, "R9 idle rsp_valid", {63'd0, rsp_valid}, 64'd0);
        check(irq == 1'b0, "R3 reset irq", {63'd0, irq}, 64'd0);
        read_ctrl(32'd0, "R3 reset control");
        read_tval(1'b0, "R1 reset compare zero");
        cyc();
        check(rsp_valid == 1'b0, "R9 no response without request", {63'd0, rsp_valid}, 64'd0);
    endtask

    task automatic t_enable_fires();
        write_ctrl(32'hFFFF_FFFD);          // bit2 and upper bits must be ignored
        cyc();
        read_ctrl(32'd5, "R4 status after enable, R3 read-only bits");
        check(irq == 1'b1, "R6 irq when fired unmasked", {63'd0, irq}, 64'd1);
    endtask

    task automatic t_countdown();
        write_tval(1'b0, 32'd5);
        repeat (3) cyc();
        check(irq == 1'b0, "R4 armed before reaching compare", {63'd0, irq}, 64'd0);
        read_tval(1'b0, "R2 compare from count plus value");
        check(irq == 1'b0, "R4 still armed one before", {63'd0, irq}, 64'd0);
        cyc();
        check(irq == 1'b1, "R4 fires when count equals compare", {63'd0, irq}, 64'd1);
    endtask

    task automatic t_mask();
        write_ctrl(32'd3);
        cyc();
        check(irq == 1'b0, "R6 mask silences irq", {63'd0, irq}, 64'd0);
        read_ctrl(32'd7, "R6 status stays with mask");
        write_ctrl(32'd1);
        cyc();
        check(irq == 1'b1, "R6 irq returns on unmask", {63'd0, irq}, 64'd1);
    endtask

    task automatic t_negative();
        write_tval(1'b0, 32'hFFFF_FFF0);
        cyc();
        read_tval(1'b0, "R2 negative value sign-extended");
        read_ctrl(32'd5, "R4 already past compare");
    endtask

    task automatic t_disable();
        write_ctrl(32'd0);
        read_ctrl(32'd0, "R5 status hidden when disabled");
        check(irq == 1'b0, "R5 irq low when disabled", {63'd0, irq}, 64'd0);
        repeat (5) cyc();
        read_tval(1'b0, "R1 view keeps counting while disabled");
    endtask

    task automatic t_wrap();
        sys_count = 64'h0000_0001_FFFF_FFF0;
        write_tval(1'b0, 32'h0000_0100);
        write_ctrl(32'd1);
        repeat (2) cyc();
        read_ctrl(32'd1, "R4 armed across low-word wrap");
        read_tval(1'b0, "R1 remaining across low-word wrap");
        repeat (260) cyc();
        read_ctrl(32'd5, "R4 fired after wrap");
        write_tval(1'b0, 32'd50);
        cyc();
        read_ctrl(32'd1, "R4 rewrite returns to armed");
    endtask

    task automatic t_priv_gate();
        logic [31:0] rd; logic [63:0] c;
        perm_frame_rw = 1'b0;
        access(1'b0, TVAL, 1'b0, '0, rd, c);
        check(rd == 32'd0, "R7 denied read is zero", {32'd0, rd}, 64'd0);
        access(1'b0, TVAL, 1'b1, 32'h1234, rd, c);
        access(1'b0, CTRL, 1'b1, 32'd0, rd, c);
        perm_frame_rw = 1'b1;
        read_tval(1'b0, "R7 denied write ignored");
        read_ctrl(32'd1, "R7 denied control write ignored");
    endtask

    task automatic t_user_gate();
        logic [31:0] rd; logic [63:0] c;
        perm_user_timer = 1'b0;
        access(1'b1, TVAL, 1'b0, '0, rd, c);
        check(rd == 32'd0, "R8 user denied without user enable", {32'd0, rd}, 64'd0);
        access(1'b1, TVAL, 1'b1, 32'h777, rd, c);
        perm_user_timer = 1'b1; perm_frame_rw = 1'b0;
        access(1'b1, TVAL, 1'b0, '0, rd, c);
        check(rd == 32'd0, "R8 user denied without frame permission", {32'd0, rd}, 64'd0);
        access(1'b1, TVAL, 1'b1, 32'h888, rd, c);
        perm_frame_rw = 1'b1;
        read_tval(1'b1, "R8 user read allowed, denied writes ignored");
        write_tval(1'b1, 32'd1000);
        read_tval(1'b0, "R8 user write reaches compare");
    endtask

    task automatic t_unmapped();
        logic [31:0] rd; logic [63:0] c;
        access(1'b0, 12'h030, 1'b1, 32'hFFFF_FFFF, rd, c);
        access(1'b0, 12'h030, 1'b0, '0, rd, c);
        check(rd == 32'd0, "R9 unmapped read zero", {32'd0, rd}, 64'd0);
        read_tval(1'b0, "R9 unmapped write no effect");
        read_ctrl(32'd1, "R9 unmapped write leaves control");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_enable_fires();
        t_countdown();
        t_mask();
        t_negative();
        t_disable();
        t_wrap();
        t_priv_gate();
        t_user_gate();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule